// File: doc/BRIEF.md
# DMA Request Sampling Sequencer

This block watches the active-low request line of one external device and sequences the bus cycles of one DMA channel on the bus clock. Four static mode inputs shape the sequence. One selects burst or cycle-steal operation. One selects dual-address or single-address transfers. A dual-address transfer is a read cycle followed by a write cycle, and a single-address transfer is one bus cycle. One selects level or falling-edge detection of the request. The last selects whether the acknowledge appears in the read cycle or in the write cycle of a dual-address transfer.

When the sequencer samples the request and finds it valid, it pulses an accept strobe. After a fixed start latency it opens a bus cycle. The latency is longer for edge detection than for level detection. Toward an abstract bus interface the block shows a start pulse and a phase code for each bus cycle, and it waits for a done pulse from that interface. The point at which the request line is sampled again depends on the mode combination. A request accepted during a transfer is held and served when the current transfer finishes. The mode inputs are expected to change only while reset is asserted.

Top module: `dreq_seq`

## Requirements
- R1: While reset is asserted, accept_o, cyc_start_o and ack_o are 0 and phase_o is 2'b00.
- R2: req_n passes through one register stage. With level detection (edge_mode=0), a sampled low request raises accept_o in the clock after the edge that captured it. The first bus cycle then starts (cyc_start_o=1) exactly 4 clocks after the accept_o clock.
- R3: With edge detection (edge_mode=1), a registered high-to-low transition counts as a request. The transition is latched until accepted, and the first bus cycle starts exactly 5 clocks after accept_o. A request held low after it has been consumed gives no further accept.
- R4: phase_o encodes the bus cycle: 2'b00 none, 2'b01 read, 2'b10 write, 2'b11 single. cyc_start_o pulses in the first clock of each bus cycle. phase_o holds until the clock in which bus_done is 1.
- R5: With single_mode=0, each transfer is a read cycle followed by a write cycle. The write cycle starts in the clock after the read cycle's bus_done.
- R6: With single_mode=0, the next request sample comes at a point set by the detection mode. With level detection it is one clock after the write cycle starts. With edge detection it is the clock in which the read cycle's bus_done is 1.
- R7: With single_mode=1, the next request sample also depends on the detection mode. With level detection it is one clock after the bus cycle starts. With edge detection it is one clock after accept_o.
- R8: From that sample point the request is sampled on every clock until accepted. An accepted request is served when the current transfer ends. With burst_mode=1 its first bus cycle starts in the clock after the final bus_done. With burst_mode=0 one idle clock comes first.
- R9: ack_o is 1 throughout every single-address bus cycle. For dual-address transfers it is 1 throughout the write cycle when ack_on_write=1, and throughout the read cycle when ack_on_write=0.
- R10: While rem_count is 0 no request is accepted. A pending level request is accepted in the clock in which rem_count becomes nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | External transfer request, active low |
| burst_mode | input | 1 | 1 = burst, 0 = cycle steal |
| single_mode | input | 1 | 1 = single-address, 0 = dual-address |
| edge_mode | input | 1 | 1 = falling-edge detection, 0 = level detection |
| ack_on_write | input | 1 | Dual-address: 1 = acknowledge in write cycle, 0 = in read cycle |
| rem_count | input | CNT_W | Transfers remaining; 0 blocks acceptance |
| bus_done | input | 1 | Bus interface: current bus cycle finishes this clock |
| accept_o | output | 1 | Request-accepted strobe, one clock |
| cyc_start_o | output | 1 | First clock of a bus cycle |
| phase_o | output | 2 | Current bus cycle kind |
| ack_o | output | 1 | Transfer acknowledge to the device, active high |

## Verification
Every result is due a fixed number of clocks after its cause. Accept follows the captured request by one clock. The first start follows accept by 4 or 5 clocks. A write start follows the read's done by one clock. A queued transfer starts one or two clocks after the final done. The bench drives inputs 1 ns after a rising edge and logs outputs on falling edges against a cycle counter, so every expected cycle comes from plain arithmetic on the accept cycle. A bus responder answers each cycle start with a done one clock later, which fixes every transfer's length and places each second sample point at a known cycle for all sixteen mode combinations.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RD,
      ST_WR,
      ST_SG,
      ST_GAP
   } seq_st_t;

   localparam logic [1:0] PH_NONE = 2'b00;
   localparam logic [1:0] PH_RD   = 2'b01;
   localparam logic [1:0] PH_WR   = 2'b10;
   localparam logic [1:0] PH_SG   = 2'b11;
endpackage

// File: rtl/dreq_detect.sv
module dreq_detect #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   input  logic edge_mode,
   input  logic consume,
   output logic det
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   req_now;
   logic                   req_prev;
   logic                   fall;
   logic                   pend;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("dreq_detect: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= 1'b1;
            else        chain <= req_n;
         end
      end else begin : g_multi_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], req_n};
         end
      end
   endgenerate

   assign req_now = chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_prev <= 1'b1;
         pend     <= 1'b0;
      end else begin
         req_prev <= req_now;
         pend     <= (pend | fall) & ~consume;
      end
   end

   assign fall = req_prev & ~req_now;
   assign det  = edge_mode ? (pend | fall) : ~req_now;

   // After a consumed edge, a line that stays put yields no new request.
   p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && $past(consume) && $stable(req_now)) |-> !det)
      else $error("edge request re-detected without a new transition");
endmodule

// File: rtl/dreq_arm.sv
module dreq_arm
   import dreq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    single_mode,
   input  logic    edge_mode,
   input  logic    accept,
   input  seq_st_t st,
   input  logic    start_q,
   input  logic    bus_done,
   input  logic    queued,
   output logic    sample_en
);
   logic armed;
   logic arm_set;
   logic keep_on_accept;
   logic rd_end_win;

   always_comb begin
      if (single_mode)
         arm_set = edge_mode ? accept : (st == ST_SG && start_q);
      else
         arm_set = edge_mode ? (st == ST_RD && bus_done) : (st == ST_WR && start_q);
   end

   assign keep_on_accept = single_mode & edge_mode;
   assign rd_end_win     = ~single_mode & edge_mode & (st == ST_RD) & bus_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         armed <= 1'b0;
      else if (accept && !keep_on_accept) armed <= 1'b0;
      else if (arm_set)                   armed <= 1'b1;
   end

   assign sample_en = (st == ST_IDLE) | ((armed | rd_end_win) & ~queued);

   // Dual-address level mode never samples during a read cycle.
   p_dual_level_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_mode && !edge_mode && st == ST_RD) |-> !sample_en)
      else $error("request sampled during read in dual level mode");
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
   import dreq_pkg::*;
#(
   parameter int LVL_LAT  = 4,
   parameter int EDGE_LAT = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       burst_mode,
   input  logic       single_mode,
   input  logic       edge_mode,
   input  logic       ack_on_write,
   input  logic       accept,
   input  logic       bus_done,
   output seq_st_t    st,
   output logic       start_q,
   output logic       queued,
   output logic [1:0] phase,
   output logic       ack
);
   localparam int MAXL = (LVL_LAT > EDGE_LAT) ? LVL_LAT : EDGE_LAT;
   localparam int CW   = $clog2(MAXL + 1);
   localparam logic [CW-1:0] LOAD_LVL  = CW'(LVL_LAT - 2);
   localparam logic [CW-1:0] LOAD_EDGE = CW'(EDGE_LAT - 2);

   generate
      if (LVL_LAT < 2 || EDGE_LAT < 2) begin : g_bad_lat
         $error("dreq_fsm: start latencies must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   seq_st_t       first_bus;
   logic          end_xfer;
   logic          next_q;

   assign first_bus = single_mode ? ST_SG : ST_RD;
   assign end_xfer  = bus_done && (st == ST_SG || st == ST_WR);
   assign next_q    = queued | (accept & (st != ST_IDLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         start_q <= 1'b0;
         queued  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         queued  <= next_q;
         unique case (st)
            ST_IDLE: if (accept) begin
               st  <= ST_WAIT;
               cnt <= edge_mode ? LOAD_EDGE : LOAD_LVL;
            end
            ST_WAIT: if (cnt == '0) begin
               st      <= first_bus;
               start_q <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
            ST_RD: if (bus_done) begin
               st      <= ST_WR;
               start_q <= 1'b1;
            end
            ST_WR, ST_SG: if (end_xfer) begin
               if (next_q && burst_mode) begin
                  st      <= first_bus;
                  start_q <= 1'b1;
                  queued  <= 1'b0;
               end else if (next_q) begin
                  st <= ST_GAP;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_GAP: begin
               st      <= first_bus;
               start_q <= 1'b1;
               queued  <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         ST_RD:   begin phase = PH_RD;   ack = ~ack_on_write; end
         ST_WR:   begin phase = PH_WR;   ack = ack_on_write;  end
         ST_SG:   begin phase = PH_SG;   ack = 1'b1;          end
         default: begin phase = PH_NONE; ack = 1'b0;          end
      endcase
   end

   p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_NONE && !bus_done) |=> (phase == $past(phase)))
      else $error("bus phase changed before done");

   p_wr_follows_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && st == ST_WR) |-> $past(st == ST_RD && bus_done))
      else $error("write cycle not preceded by finished read");

   p_gap_then_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP) |=> (start_q && st != ST_GAP))
      else $error("idle clock not followed by queued start");

   p_ack_not_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ($past(st) != ST_IDLE))
      else $error("acknowledge raised straight from idle");
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
   import dreq_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int LVL_LAT     = 4,
   parameter int EDGE_LAT    = 5,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_n,
   input  logic             burst_mode,
   input  logic             single_mode,
   input  logic             edge_mode,
   input  logic             ack_on_write,
   input  logic [CNT_W-1:0] rem_count,
   input  logic             bus_done,
   output logic             accept_o,
   output logic             cyc_start_o,
   output logic [1:0]       phase_o,
   output logic             ack_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("dreq_seq: CNT_W must be at least 1");
      end
   endgenerate

   logic    det;
   logic    sample_en;
   logic    accept;
   logic    start_q;
   logic    queued;
   seq_st_t st;

   assign accept = sample_en & det & (rem_count != '0);

   dreq_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_n     (req_n),
      .edge_mode (edge_mode),
      .consume   (accept),
      .det       (det)
   );

   dreq_arm u_arm (
      .clk         (clk),
      .rst_n       (rst_n),
      .single_mode (single_mode),
      .edge_mode   (edge_mode),
      .accept      (accept),
      .st          (st),
      .start_q     (start_q),
      .bus_done    (bus_done),
      .queued      (queued),
      .sample_en   (sample_en)
   );

   dreq_fsm #(.LVL_LAT(LVL_LAT), .EDGE_LAT(EDGE_LAT)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .burst_mode   (burst_mode),
      .single_mode  (single_mode),
      .edge_mode    (edge_mode),
      .ack_on_write (ack_on_write),
      .accept       (accept),
      .bus_done     (bus_done),
      .st           (st),
      .start_q      (start_q),
      .queued       (queued),
      .phase        (phase_o),
      .ack          (ack_o)
   );

   assign accept_o    = accept;
   assign cyc_start_o = start_q;

   // A start never coincides with an empty phase.
   p_start_has_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |-> (phase_o != PH_NONE))
      else $error("bus cycle start without phase");
endmodule

// File: tb/sim_dreq_seq.sv
module sim_dreq_seq;
   localparam int LVL  = 4;
   localparam int EDGE = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_n = 1'b1;
   logic       burst_mode = 1'b0, single_mode = 1'b0, edge_mode = 1'b0, ack_on_write = 1'b0;
   logic [7:0] rem_count = 8'd3;
   logic       bus_done = 1'b0;
   logic       accept_o, cyc_start_o, ack_o;
   logic [1:0] phase_o;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit log_clr = 1'b0;
   int n_acc, n_st, n_ack, ack_first;
   int acc_c [8];
   int st_c  [8];
   int st_ph [8];

   dreq_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .burst_mode(burst_mode),
      .single_mode(single_mode), .edge_mode(edge_mode), .ack_on_write(ack_on_write),
      .rem_count(rem_count), .bus_done(bus_done), .accept_o(accept_o),
      .cyc_start_o(cyc_start_o), .phase_o(phase_o), .ack_o(ack_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Event log, written only here.
   initial begin
      forever begin
         @(negedge clk);
         if (log_clr) begin
            n_acc = 0; n_st = 0; n_ack = 0; ack_first = -1;
         end else begin
            if (accept_o) begin
               if (n_acc < 8) acc_c[n_acc] = cyc;
               n_acc++;
            end
            if (cyc_start_o) begin
               if (n_st < 8) begin st_c[n_st] = cyc; st_ph[n_st] = int'(phase_o); end
               n_st++;
            end
            if (ack_o) begin
               if (ack_first < 0) ack_first = cyc;
               n_ack++;
            end
         end
      end
   end

   // Bus responder: done one clock after each start.
   initial begin
      forever begin
         @(negedge clk);
         if (cyc_start_o) begin
            @(posedge clk); #1 bus_done = 1'b1;
            @(posedge clk); #1 bus_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      log_clr = 1'b1;
      @(negedge clk);
      @(negedge clk);
      log_clr = 1'b0;
   endtask

   task automatic do_reset(input bit b, input bit s, input bit e, input bit aw);
      rst_n = 1'b0;
      req_n = 1'b1;
      rem_count = 8'd3;
      burst_mode = b; single_mode = s; edge_mode = e; ack_on_write = aw;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 reset outputs", int'({accept_o, cyc_start_o, ack_o, phase_o}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      clear_log();
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic run_case(input bit b, input bit s, input bit e, input bit aw, input bit late);
      int a, lat, s1, en, p, f, acc2, s2, per, guard;
      do_reset(b, s, e, aw);
      a = cyc + 1;
      req_n = 1'b0;
      lat = e ? EDGE : LVL;
      s1  = a + lat;
      en  = s ? s1 + 1 : s1 + 3;
      if (s) p = e ? a + 1 : s1 + 1;
      else   p = e ? s1 + 1 : s1 + 3;
      if (e) begin
         f = late ? (s ? a + 3 : s1 + 2) : a + 2;
         @(posedge clk); #1 req_n = 1'b1;
         repeat (f - 1 - a) @(posedge clk);
         #1 req_n = 1'b0;
         acc2 = (p > f) ? p : f;
      end else begin
         guard = 0;
         while (n_acc < 2 && guard < 60) begin @(negedge clk); guard++; end
         @(posedge clk); #1 req_n = 1'b1;
         acc2 = p;
      end
      repeat (40) @(posedge clk);
      #1;
      s2  = b ? en + 1 : en + 2;
      per = s ? 1 : 2;
      chk(e ? "R3 accept count, held low ignored" : "R2 accept count", n_acc, 2);
      chk(e ? "R3 first accept" : "R2 first accept", acc_c[0], a);
      chk(e ? "R3 start latency" : "R2 start latency", st_c[0], s1);
      chk("R4 first phase code", st_ph[0], s ? 3 : 1);
      chk("R4 start count", n_st, 2 * per);
      if (!s) begin
         chk("R5 write start", st_c[1], s1 + 2);
         chk("R4 write phase code", st_ph[1], 2);
         chk("R6 second sample point", acc_c[1], acc2);
      end else begin
         chk("R7 second sample point", acc_c[1], acc2);
      end
      chk("R8 queued transfer start", st_c[per], s2);
      chk("R8 queued transfer phase", st_ph[per], s ? 3 : 1);
      chk("R9 ack cycles", n_ack, 4);
      chk("R9 first ack", ack_first, (!s && aw) ? s1 + 2 : s1);
   endtask

   task automatic run_empty();
      int c;
      do_reset(1'b1, 1'b0, 1'b0, 1'b0);
      rem_count = 8'd0;
      req_n = 1'b0;
      repeat (15) @(posedge clk);
      #1;
      chk("R10 no accept at zero count", n_acc, 0);
      chk("R10 no start at zero count", n_st, 0);
      rem_count = 8'd3;
      c = cyc;
      @(posedge clk); #1 req_n = 1'b1;
      repeat (30) @(posedge clk);
      #1;
      chk("R10 accept count", n_acc, 1);
      chk("R10 accept when count nonzero", acc_c[0], c);
      chk("R10 start after release", st_c[0], c + LVL);
   endtask

   initial begin
      for (int m = 0; m < 16; m++) begin
         run_case(m[3], m[2], m[1], m[0], 1'b0);
      end
      for (int m = 0; m < 4; m++) begin
         run_case(m[1], m[0], 1'b1, 1'b0, 1'b1);
      end
      run_empty();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule